// File: doc/BRIEF.md
# Programmable Serial Audio Receiver

This block takes in a multi-channel serial audio stream and delivers two chosen channel samples as parallel words. An external device is clock master and drives the bit clock, the frame clock and the data line. The block runs on its own system clock. It passes the three serial lines through two-flop synchronizers and finds bit-clock edges by comparing successive synchronized values, so the bit clock has to be several times slower than the system clock.

Framing is set at run time through static configuration inputs:

- channels per frame and bits per channel;
- audio word length and the number of pad bits ahead of the word;
- bit order;
- which bit-clock edge latches the data and frame lines;
- frame-clock polarity;
- whether the frame-clock edge comes one bit early.

A frame starts at the leading active edge of the frame clock, whether that clock is a one-bit pulse or a level of about half the frame. Bits are then counted into channel slots. Pad bits are dropped. The words of the two selected slots are collected and presented together, with a one-cycle valid strobe, once per frame.

Top module: `sarx_top`

## Requirements
- R1: While reset is asserted and right after it, smp_a and smp_b are zero and smp_valid and frm_err are low.
- R2: Data and frame lines are latched on the rising bit-clock edge when cfg_fall is 0 and on the falling edge when cfg_fall is 1.
- R3: With cfg_finv at 0 the frame clock is high at the start of a frame; with cfg_finv at 1 it is low. A frame starts at the transition into the active level.
- R4: With cfg_early at 1, the frame-clock transition is taken to occur one bit period before bit 0 of the frame.
- R5: A one-bit-wide frame pulse and a roughly 50% duty frame level give the same framing, because both are detected from their leading active edge.
- R6: With cfg_msb_first at 1 the first received word bit is the MSB; with it at 0 the first is the LSB. The word is right-aligned in the output, with its LSB at bit 0 and zeros above the word length.
- R7: Within a slot, the first cfg_lead bits and any bits after the word are ignored. Setting cfg_lead to bits-per-channel minus word length gives right-justified reception.
- R8: smp_a carries the word of slot cfg_slot_a and smp_b the word of slot cfg_slot_b, with slots numbered from 0 at frame start. cfg_slot_b must be greater than cfg_slot_a.
- R9: smp_valid pulses high for exactly one cycle per frame, a fixed delay after the last bit of slot cfg_slot_b is latched. smp_a and smp_b change only in that cycle.
- R10: At each frame start after the first, frm_err is set if the number of bits since the previous start differs from channels times bits per channel, and cleared otherwise. It changes only after a bit-clock latch event.
- R11: Bits per channel up to 32 and channels per frame up to 256 are supported, including a full 32-bit word in a 32-bit slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_bclk | input | 1 | Serial bit clock from the external master |
| ser_fclk | input | 1 | Serial frame clock from the external master |
| ser_data | input | 1 | Serial data line |
| cfg_chans | input | 9 | Channels per frame, 1 to 256 |
| cfg_bits | input | 6 | Bits per channel, 1 to 32 |
| cfg_word | input | 6 | Audio word length in bits |
| cfg_lead | input | 6 | Pad bits ahead of the word in each slot |
| cfg_slot_a | input | 8 | Slot routed to smp_a |
| cfg_slot_b | input | 8 | Slot routed to smp_b, greater than cfg_slot_a |
| cfg_fall | input | 1 | 1 selects the falling latch edge |
| cfg_finv | input | 1 | 1 means the frame clock is low at frame start |
| cfg_early | input | 1 | 1 means the frame-clock edge leads bit 0 by one bit |
| cfg_msb_first | input | 1 | 1 means the MSB arrives first |
| smp_a | output | 32 | Right-aligned sample from slot A |
| smp_b | output | 32 | Right-aligned sample from slot B |
| smp_valid | output | 1 | One-cycle strobe for new samples |
| frm_err | output | 1 | Frame length mismatch at the latest frame start |

## Verification
A bit or slot counter that has slipped moves the word window. The error shows in the very next sample pair as a shifted or bit-reversed word, and frm_err rises at the following frame start. A wrong start-detection state shows up first as missing or extra valid strobes within one frame. The bench drives pad bits as ones, so a misplaced pad window lets set bits into the high part of the sample. It also counts strobes in each burst, so a lost or doubled emission is caught.

// File: rtl/sarx_pkg.sv
// Shared constants and types for the serial audio receiver.
// Assumes nothing beyond the parameter defaults given here.
package sarx_pkg;
    localparam int SARX_MAX_CH   = 256;
    localparam int SARX_MAX_BITS = 32;

    // Framing mode bits that are shared by the framer and the capture logic
    typedef struct packed {
        logic fall;       // latch on falling bit-clock edge
        logic finv;       // frame clock low at frame start
        logic early;      // frame-clock edge one bit before bit 0
        logic msb_first;  // first received word bit is the MSB
    } sarx_mode_t;
endpackage

// File: rtl/sarx_sync.sv
// Two-flop synchronizer, one chain per bit.
// Assumes each input bit is independent and changes slowly compared with clk.
module sarx_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_chain
            logic meta_q;
            logic stab_q;
            // Two-stage capture of one asynchronous line
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    stab_q <= 1'b0;
                end else begin
                    meta_q <= din[gi];
                    stab_q <= meta_q;
                end
            end
            assign dout[gi] = stab_q;
        end
    endgenerate
endmodule

// File: rtl/sarx_framer.sv
// Framer: finds latch events on the synchronized bit clock and frame starts
// from the frame clock's leading active edge. Tracks the position of each
// latched bit (slot and bit in slot) and checks the frame length.
// Assumes the bit clock runs well below clk/4 and that configuration is
// static between resets.
module sarx_framer
    import sarx_pkg::*;
#(
    parameter int MAX_CH   = SARX_MAX_CH,
    parameter int MAX_BITS = SARX_MAX_BITS,
    localparam int CHW  = $clog2(MAX_CH + 1),
    localparam int SLW  = $clog2(MAX_CH),
    localparam int BW   = $clog2(MAX_BITS + 1),
    localparam int POSW = $clog2(MAX_BITS),
    localparam int FLW  = CHW + BW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bclk_s,
    input  logic            fclk_s,
    input  logic [CHW-1:0]  cfg_chans,
    input  logic [BW-1:0]   cfg_bits,
    input  sarx_mode_t      mode,
    output logic            bit_ev,
    output logic            bit_ok,
    output logic [POSW-1:0] pos_now,
    output logic [SLW-1:0]  slot_now,
    output logic            frm_err
);
    logic            bclk_q, act_q, pend_q, synced_q;
    logic [POSW-1:0] pos_q;
    logic [SLW-1:0]  slot_q;
    logic [FLW-1:0]  cnt_q;
    logic            act, lead, start, last_bit, last_slot;
    logic [FLW-1:0]  frame_len;

    // Latch event selection, start detection and next position
    always_comb begin
        bit_ev    = mode.fall ? (bclk_q & ~bclk_s) : (bclk_s & ~bclk_q);
        act       = fclk_s ^ mode.finv;
        lead      = act & ~act_q;
        start     = mode.early ? pend_q : lead;
        bit_ok    = start | synced_q;
        last_bit  = (BW'(pos_q) == cfg_bits - BW'(1));
        last_slot = (CHW'(slot_q) == cfg_chans - CHW'(1));
        frame_len = FLW'(cfg_chans) * FLW'(cfg_bits);
        if (start) begin
            pos_now  = '0;
            slot_now = '0;
        end else if (last_bit) begin
            pos_now  = '0;
            slot_now = last_slot ? '0 : slot_q + SLW'(1);
        end else begin
            pos_now  = pos_q + POSW'(1);
            slot_now = slot_q;
        end
    end

    // Framing state, advanced once per latch event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q   <= 1'b0;
            act_q    <= 1'b1;
            pend_q   <= 1'b0;
            synced_q <= 1'b0;
            pos_q    <= '0;
            slot_q   <= '0;
            cnt_q    <= '0;
            frm_err  <= 1'b0;
        end else begin
            bclk_q <= bclk_s;
            if (bit_ev) begin
                act_q  <= act;
                pend_q <= lead;
                if (bit_ok) begin
                    pos_q  <= pos_now;
                    slot_q <= slot_now;
                end
                if (start) begin
                    cnt_q    <= '0;
                    synced_q <= 1'b1;
                    if (synced_q)
                        frm_err <= (cnt_q != frame_len - FLW'(1));
                end else if (cnt_q != '1) begin
                    cnt_q <= cnt_q + FLW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/sarx_capture.sv
// Capture: assembles the words of two selected slots, skipping pad bits,
// and presents them together with a one-cycle strobe once per frame.
// Assumes cfg_lead + cfg_word <= cfg_bits and slot B after slot A.
module sarx_capture
    import sarx_pkg::*;
#(
    parameter int MAX_CH   = SARX_MAX_CH,
    parameter int MAX_BITS = SARX_MAX_BITS,
    localparam int SLW  = $clog2(MAX_CH),
    localparam int BW   = $clog2(MAX_BITS + 1),
    localparam int POSW = $clog2(MAX_BITS),
    localparam int NL   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take,
    input  logic                din,
    input  logic [POSW-1:0]     pos_now,
    input  logic [SLW-1:0]      slot_now,
    input  logic [BW-1:0]       cfg_bits,
    input  logic [BW-1:0]       cfg_word,
    input  logic [BW-1:0]       cfg_lead,
    input  logic [SLW-1:0]      cfg_slot_a,
    input  logic [SLW-1:0]      cfg_slot_b,
    input  sarx_mode_t          mode,
    output logic [MAX_BITS-1:0] smp_a,
    output logic [MAX_BITS-1:0] smp_b,
    output logic                smp_valid
);
    logic [BW-1:0]       pos_x, k, idx_full;
    logic [POSW-1:0]     idx;
    logic                in_word, emit_q;
    logic [SLW-1:0]      sel [NL];
    logic [MAX_BITS-1:0] acc [NL];

    assign sel[0] = cfg_slot_a;
    assign sel[1] = cfg_slot_b;

    // Word window and bit index inside the word for the current bit
    always_comb begin
        pos_x    = BW'(pos_now);
        k        = pos_x - cfg_lead;
        in_word  = (pos_x >= cfg_lead) &&
                   ({1'b0, pos_x} < ({1'b0, cfg_lead} + {1'b0, cfg_word}));
        idx_full = mode.msb_first ? (cfg_word - BW'(1) - k) : k;
        idx      = idx_full[POSW-1:0];
    end

    genvar gl;
    generate
        for (gl = 0; gl < NL; gl++) begin : g_lane
            logic [MAX_BITS-1:0] acc_q, acc_n;
            // Next accumulator value: cleared at slot start, one bit written
            always_comb begin
                acc_n = (pos_now == '0) ? '0 : acc_q;
                if (in_word)
                    acc_n[idx] = din;
            end
            // Accumulator update for bits of the selected slot
            always_ff @(posedge clk) begin
                if (!rst_n)
                    acc_q <= '0;
                else if (take && slot_now == sel[gl])
                    acc_q <= acc_n;
            end
            assign acc[gl] = acc_q;
        end
    endgenerate

    // Emission after the last bit of slot B, outputs and strobe together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            emit_q    <= 1'b0;
            smp_a     <= '0;
            smp_b     <= '0;
            smp_valid <= 1'b0;
        end else begin
            emit_q    <= take && (slot_now == cfg_slot_b) &&
                         (pos_x == cfg_bits - BW'(1));
            smp_valid <= emit_q;
            if (emit_q) begin
                smp_a <= acc[0];
                smp_b <= acc[1];
            end
        end
    end
endmodule

// File: rtl/sarx_top.sv
// Programmable serial audio receiver, top level. Synchronizes the serial
// lines, frames the stream and captures two selected slots.
// Assumes the external bit clock is slower than a quarter of clk.
module sarx_top
    import sarx_pkg::*;
#(
    parameter int MAX_CH   = SARX_MAX_CH,
    parameter int MAX_BITS = SARX_MAX_BITS,
    localparam int CHW  = $clog2(MAX_CH + 1),
    localparam int SLW  = $clog2(MAX_CH),
    localparam int BW   = $clog2(MAX_BITS + 1),
    localparam int POSW = $clog2(MAX_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_bclk,
    input  logic                ser_fclk,
    input  logic                ser_data,
    input  logic [CHW-1:0]      cfg_chans,
    input  logic [BW-1:0]       cfg_bits,
    input  logic [BW-1:0]       cfg_word,
    input  logic [BW-1:0]       cfg_lead,
    input  logic [SLW-1:0]      cfg_slot_a,
    input  logic [SLW-1:0]      cfg_slot_b,
    input  logic                cfg_fall,
    input  logic                cfg_finv,
    input  logic                cfg_early,
    input  logic                cfg_msb_first,
    output logic [MAX_BITS-1:0] smp_a,
    output logic [MAX_BITS-1:0] smp_b,
    output logic                smp_valid,
    output logic                frm_err
);
    logic [2:0]      ser_s;
    sarx_mode_t      mode;
    logic            bit_ev, bit_ok;
    logic [POSW-1:0] pos_now;
    logic [SLW-1:0]  slot_now;

    assign mode = '{fall: cfg_fall, finv: cfg_finv, early: cfg_early,
                    msb_first: cfg_msb_first};

    sarx_sync #(.W(3)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ser_data, ser_fclk, ser_bclk}),
        .dout (ser_s)
    );

    sarx_framer #(.MAX_CH(MAX_CH), .MAX_BITS(MAX_BITS)) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk_s   (ser_s[0]),
        .fclk_s   (ser_s[1]),
        .cfg_chans(cfg_chans),
        .cfg_bits (cfg_bits),
        .mode     (mode),
        .bit_ev   (bit_ev),
        .bit_ok   (bit_ok),
        .pos_now  (pos_now),
        .slot_now (slot_now),
        .frm_err  (frm_err)
    );

    sarx_capture #(.MAX_CH(MAX_CH), .MAX_BITS(MAX_BITS)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (bit_ev & bit_ok),
        .din       (ser_s[2]),
        .pos_now   (pos_now),
        .slot_now  (slot_now),
        .cfg_bits  (cfg_bits),
        .cfg_word  (cfg_word),
        .cfg_lead  (cfg_lead),
        .cfg_slot_a(cfg_slot_a),
        .cfg_slot_b(cfg_slot_b),
        .mode      (mode),
        .smp_a     (smp_a),
        .smp_b     (smp_b),
        .smp_valid (smp_valid)
    );
endmodule

// File: rtl/sarx_chk.sv
// Checker for sarx_top: strobe shape, output hold, error timing and
// position range. Attached by the bind statement at the end of this file.
module sarx_chk #(
    parameter int DW   = 32,
    parameter int BW   = 6,
    parameter int POSW = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bit_ev,
    input logic            bit_ok,
    input logic [POSW-1:0] pos_now,
    input logic [BW-1:0]   cfg_bits,
    input logic [DW-1:0]   smp_a,
    input logic [DW-1:0]   smp_b,
    input logic            smp_valid,
    input logic            frm_err
);
    // R9: strobe is a single cycle
    p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid);

    // R9: samples hold while no strobe
    p_hold_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |-> ($stable(smp_a) && $stable(smp_b)));

    // R9: strobe follows a latch event by a fixed two cycles
    p_strobe_after_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> $past(bit_ev, 2));

    // R10: the error flag moves only after a latch event
    p_err_on_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_ev |=> $stable(frm_err));

    // R11: tracked bit position stays inside the configured slot width
    p_pos_inside_slot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_ev && bit_ok) |-> (BW'(pos_now) < cfg_bits));
endmodule

bind sarx_top sarx_chk #(.DW(MAX_BITS), .BW(BW), .POSW(POSW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_ev   (bit_ev),
    .bit_ok   (bit_ok),
    .pos_now  (pos_now),
    .cfg_bits (cfg_bits),
    .smp_a    (smp_a),
    .smp_b    (smp_b),
    .smp_valid(smp_valid),
    .frm_err  (frm_err)
);

// File: tb/sarx_top_tb_top.sv
// Directed bench for sarx_top: one task per scenario, each checking itself.
module sarx_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_bclk = 1'b0, ser_fclk = 1'b0, ser_data = 1'b0;
    logic [8:0]  cfg_chans = 9'd2;
    logic [5:0]  cfg_bits = 6'd16, cfg_word = 6'd16, cfg_lead = 6'd0;
    logic [7:0]  cfg_slot_a = 8'd0, cfg_slot_b = 8'd1;
    logic        cfg_fall = 1'b0, cfg_finv = 1'b0, cfg_early = 1'b0, cfg_msb_first = 1'b1;
    logic [31:0] smp_a, smp_b;
    logic        smp_valid, frm_err;

    logic        pulse_mode = 1'b0;
    int          n_checks = 0, n_errors = 0, n_valid = 0;

    always #10 clk = ~clk;

    sarx_top dut_i (
        .clk(clk), .rst_n(rst_n), .ser_bclk(ser_bclk), .ser_fclk(ser_fclk),
        .ser_data(ser_data), .cfg_chans(cfg_chans), .cfg_bits(cfg_bits),
        .cfg_word(cfg_word), .cfg_lead(cfg_lead), .cfg_slot_a(cfg_slot_a),
        .cfg_slot_b(cfg_slot_b), .cfg_fall(cfg_fall), .cfg_finv(cfg_finv),
        .cfg_early(cfg_early), .cfg_msb_first(cfg_msb_first), .smp_a(smp_a),
        .smp_b(smp_b), .smp_valid(smp_valid), .frm_err(frm_err)
    );

    // Count strobes away from the active edge
    always @(negedge clk) if (rst_n && smp_valid) n_valid++;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input int s, input int seed);
        logic [31:0] w;
        logic [63:0] m;
        w = (32'(seed) * 32'h0100_0193) ^ (32'(s + 1) * 32'h9E37_79B9) ^ 32'h5A5A_C3C3;
        m = (64'd1 << cfg_word) - 64'd1;
        return w & m[31:0];
    endfunction

    function automatic logic act_at(input int g);
        int n;
        n = int'(cfg_chans) * int'(cfg_bits);
        return pulse_mode ? (g == 0) : (g < n / 2);
    endfunction

    task automatic apply_cfg(input int ch, input int bits, input int wd, input int ld,
                             input int sa, input int sb, input logic fall, input logic inv,
                             input logic early, input logic msb, input logic pulse);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_chans = 9'(ch); cfg_bits = 6'(bits); cfg_word = 6'(wd); cfg_lead = 6'(ld);
        cfg_slot_a = 8'(sa); cfg_slot_b = 8'(sb); cfg_fall = fall; cfg_finv = inv;
        cfg_early = early; cfg_msb_first = msb; pulse_mode = pulse;
        ser_bclk = fall; ser_fclk = inv; ser_data = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        n_valid = 0;
    endtask

    task automatic drive_bit(input logic d, input logic act);
        @(negedge clk);
        ser_bclk = cfg_fall;
        ser_data = d;
        ser_fclk = act ^ cfg_finv;
        repeat (4) @(negedge clk);
        ser_bclk = ~cfg_fall;
        repeat (4) @(negedge clk);
    endtask

    // Sends idle lead-in then nfr frames; extra bits inserted after frame 0
    task automatic send_burst(input int nfr, input int seed, input int extra);
        int n;
        n = int'(cfg_chans) * int'(cfg_bits);
        drive_bit(1'b0, 1'b0);
        drive_bit(1'b0, cfg_early ? act_at(0) : 1'b0);
        for (int fr = 0; fr < nfr; fr++) begin
            for (int s = 0; s < int'(cfg_chans); s++) begin
                for (int p = 0; p < int'(cfg_bits); p++) begin
                    int g, k, idx;
                    logic d;
                    logic [31:0] w;
                    g = s * int'(cfg_bits) + p;
                    w = word_of(s, seed);
                    d = 1'b1;
                    if (p >= int'(cfg_lead) && p < int'(cfg_lead) + int'(cfg_word)) begin
                        k = p - int'(cfg_lead);
                        idx = cfg_msb_first ? int'(cfg_word) - 1 - k : k;
                        d = w[idx];
                    end
                    drive_bit(d, cfg_early ? act_at((g + 1) % n) : act_at(g));
                end
            end
            if (fr == 0)
                for (int e = 0; e < extra; e++) drive_bit(1'b0, 1'b0);
        end
        repeat (20) @(negedge clk);
    endtask

    task automatic t_reset;
        apply_cfg(2, 16, 16, 0, 0, 1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R1 smp_a after reset", smp_a, 32'h0);
        check("R1 smp_b after reset", smp_b, 32'h0);
        check("R1 valid/err after reset", {30'h0, smp_valid, frm_err}, 32'h0);
    endtask

    task automatic t_basic;
        apply_cfg(2, 16, 16, 0, 0, 1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        send_burst(3, 7, 0);
        check("R8 slot A word, rising latch (R2)", smp_a, word_of(0, 7));
        check("R8 slot B word, level high start (R3)", smp_b, word_of(1, 7));
        check("R9 one strobe per frame", 32'(n_valid), 32'd3);
        check("R10 no error on correct frames", {31'h0, frm_err}, 32'h0);
    endtask

    task automatic t_early_inverted;
        apply_cfg(2, 32, 24, 0, 0, 1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        send_burst(3, 21, 0);
        check("R4 early edge slot A, falling latch R2, low start R3", smp_a, word_of(0, 21));
        check("R4 early edge slot B, trailing pad ignored R7", smp_b, word_of(1, 21));
        check("R10 early framing length ok", {31'h0, frm_err}, 32'h0);
    endtask

    task automatic t_right_lsb_pulse;
        apply_cfg(4, 20, 16, 4, 1, 3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        send_burst(3, 99, 0);
        check("R6 LSB first slot A, R7 lead pad skipped", smp_a, word_of(1, 99));
        check("R5 pulse framing slot B, R6 LSB first", smp_b, word_of(3, 99));
        check("R9 strobe count in pulse mode", 32'(n_valid), 32'd3);
    endtask

    task automatic t_wide;
        apply_cfg(6, 32, 32, 0, 2, 5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        send_burst(2, 1234, 0);
        check("R11 full 32-bit word slot A", smp_a, word_of(2, 1234));
        check("R11 full 32-bit word slot B", smp_b, word_of(5, 1234));
        check("R5 early pulse framing count R9", 32'(n_valid), 32'd2);
    endtask

    task automatic t_frame_error;
        apply_cfg(2, 8, 8, 0, 0, 1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        send_burst(2, 5, 1);
        check("R10 error set on long frame", {31'h0, frm_err}, 32'h1);
        check("R8 decode after realign", smp_b, word_of(1, 5));
        send_burst(3, 6, 0);
        check("R10 error cleared on good frames", {31'h0, frm_err}, 32'h0);
        check("R8 slot A after recovery", smp_a, word_of(0, 6));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_early_inverted();
        t_right_lsb_pulse();
        t_wide();
        t_frame_error();
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule